// File: doc/BRIEF.md
# UART Channel FIFO Control Path

This block is the buffering and flow-control core of one serial channel. It has a transmit queue and a receive queue, each sixteen bytes deep. The host writes bytes into the transmit queue and a serializer drains it. A deserializer fills the receive queue and the host drains it. A write-only control byte turns the queues on and off, flushes either one, picks one of two ready-signal policies and sets the receive threshold. From the queue fill levels the block drives an active-low transmit-ready line, an active-low receive-ready line and a receive-threshold interrupt. The receive-ready line reaches its pin only when a two-bit pin-function select chooses it.

A three-state machine holds the ready policy. `MD_HOLD` is the state out of reset and is entered on any write with the enable bit clear. In this state each direction holds a single byte, and ready lines follow empty and occupied. `MD_SINGLE` is entered on a write with enable set and the policy bit clear. In this state the queues are sixteen deep and the ready lines still follow empty and occupied. `MD_BLOCK` is entered on a write with enable set and the policy bit set. In this state transmit-ready follows free space and receive-ready follows the threshold. The transitions are:

- HOLD to SINGLE or BLOCK, when the queues are enabled.
- SINGLE to BLOCK and BLOCK to SINGLE, when the policy changes.
- SINGLE or BLOCK to HOLD, when the queues are disabled.

Entering or leaving `MD_HOLD` flushes both queues.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Each queue holds up to 16 bytes and returns them in arrival order; the head byte is visible on the pop data output before it is popped. A push into a full queue is dropped and leaves the contents unchanged, and a pop of an empty queue does nothing.
- R2: A control write decodes these fields. Bit 0 enables the queues. Bit 3 selects the block policy, which takes effect only when bit 0 is set. Bits 7:6 select the receive threshold: 00 = 1, 01 = 4, 10 = 8 and 11 = 14 bytes. Bits 5:4 are ignored. After reset the queues are disabled, the single-character policy applies and the threshold code is 00.
- R3: A control write with bit 1 set empties the receive queue in the clock of the write. A write with bit 2 set empties the transmit queue in the same way. Neither bit is stored, so a later write without it leaves the queues alone.
- R4: A control write that changes the enable bit empties both queues. A write that repeats the current enable value empties neither.
- R5: With the queues disabled, each direction holds at most one byte. A second push while that byte is waiting is dropped.
- R6: With the single-character policy, or with the queues disabled, tx_rdy_n is 0 exactly when the transmit side holds no byte.
- R7: With the single-character policy, or with the queues disabled, the internal receive-ready level is 0 exactly when at least one received byte is waiting.
- R8: With the block policy, tx_rdy_n is 0 exactly when at least one of the 16 transmit entries is free.
- R9: With the block policy, receive-ready is 0 exactly when the receive count is at or above the selected threshold. Reception continues past the threshold until the queue is full.
- R10: rx_irq is 1 exactly when the receive count is at or above the selected threshold. With the queues disabled the threshold is 1.
- R11: mf_out_n carries the receive-ready level only when alt_sel is 2'b01; for the other three codes it is held at 1.
- R12: rx_overrun becomes 1 after a receive push is dropped and stays 1. It returns to 0 only on reset or when the receive queue is emptied by R3 or R4.
- R13: A push and a pop in the same cycle on a full queue are both accepted. The count stays at full and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| alt_sel | input | 2 | Pin-function select; 2'b01 routes receive-ready to mf_out_n |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_push_data | input | 8 | Byte for the transmit queue |
| tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_pop_data | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue is not empty |
| rx_push | input | 1 | Deserializer stores a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes the head receive byte |
| rx_pop_data | output | 8 | Head of the receive queue |
| rx_avail | output | 1 | Receive queue is not empty |
| tx_rdy_n | output | 1 | Active-low transmit ready |
| mf_out_n | output | 1 | Multi-function pin, active-low receive ready when selected |
| rx_irq | output | 1 | Receive threshold reached |
| rx_overrun | output | 1 | Sticky receive drop flag |

## Verification
The bench sweeps both policies against all four threshold codes. For each pairing it fills the receive side one byte at a time from empty to one past full, then drains it, and checks ready, interrupt and pin level at every count. A threshold comparison that is off by one, or that uses equality in place of at-or-above, would drop receive-ready as soon as the count passed the threshold. The transmit side is walked the same way, so a full test using the wrong bound would show up at count 15 or 16. Further checks cover the following:

- A single-byte mode that accepts a second byte would overwrite the head.
- Flush bits that are held after the write would clear a later write.
- A full queue that rejects a push made in the same cycle as a pop would raise a false overrun.
- A pin select that decodes the wrong code would route receive-ready to the pin when it should be held at 1.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        MD_HOLD   = 2'd0,
        MD_SINGLE = 2'd1,
        MD_BLOCK  = 2'd2
    } ready_mode_e;

    localparam logic [1:0] ALT_RXRDY = 2'b01;

    localparam int BIT_EN     = 0;
    localparam int BIT_RX_CLR = 1;
    localparam int BIT_TX_CLR = 2;
    localparam int BIT_BLOCK  = 3;

endpackage

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          one_slot,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          drop
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    assign cap     = one_slot ? CW'(1) : CW'(DEPTH);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign pop_data = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= push_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count))); // R1
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R3
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !clr) |=> (count == $past(count))); // R13

endmodule

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output ready_mode_e mode,
    output logic [CW-1:0] trig_lvl,
    output logic        rx_clr,
    output logic        tx_clr
);

    ready_mode_e state_q, state_d;
    logic [1:0]  trig_code_q;
    logic        en_bit, blk_bit, flush;
    logic [1:0]  unused_cfg_bits;

    assign en_bit          = cfg_wdata[BIT_EN];
    assign blk_bit         = cfg_wdata[BIT_BLOCK];
    assign unused_cfg_bits = cfg_wdata[5:4];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= MD_HOLD;
            trig_code_q <= 2'b00;
        end else begin
            state_q <= state_d;
            if (cfg_we) trig_code_q <= cfg_wdata[7:6];
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (state_q)
                MD_HOLD: begin
                    if (en_bit) state_d = blk_bit ? MD_BLOCK : MD_SINGLE;
                end
                MD_SINGLE: begin
                    if (!en_bit)      state_d = MD_HOLD;
                    else if (blk_bit) state_d = MD_BLOCK;
                end
                MD_BLOCK: begin
                    if (!en_bit)       state_d = MD_HOLD;
                    else if (!blk_bit) state_d = MD_SINGLE;
                end
                default: state_d = MD_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        mode   = state_q;
        flush  = cfg_we && ((state_q == MD_HOLD) == en_bit);
        rx_clr = (cfg_we && cfg_wdata[BIT_RX_CLR]) || flush;
        tx_clr = (cfg_we && cfg_wdata[BIT_TX_CLR]) || flush;
        if (state_q == MD_HOLD) begin
            trig_lvl = CW'(1);
        end else begin
            unique case (trig_code_q)
                2'b00:   trig_lvl = CW'(1);
                2'b01:   trig_lvl = CW'(4);
                2'b10:   trig_lvl = CW'(8);
                default: trig_lvl = CW'(14);
            endcase
        end
    end

    AST_DISABLE_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[BIT_EN]) |=> (state_q == MD_HOLD)); // R2
    AST_BLOCK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[BIT_EN] && cfg_wdata[BIT_BLOCK]) |=> (state_q == MD_BLOCK)); // R2
    AST_ENABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (state_q == MD_HOLD) && cfg_wdata[BIT_EN]) |-> (rx_clr && tx_clr)); // R4

endmodule

// File: rtl/uart_fifo_rdy.sv
module uart_fifo_rdy
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ready_mode_e   mode,
    input  logic [CW-1:0] trig_lvl,
    input  logic [CW-1:0] tx_count,
    input  logic          tx_full,
    input  logic [CW-1:0] rx_count,
    input  logic [1:0]    alt_sel,
    output logic          tx_rdy_n,
    output logic          mf_out_n,
    output logic          rx_irq
);

    logic rx_rdy_n;

    always_comb begin
        unique case (mode)
            MD_BLOCK: begin
                tx_rdy_n = tx_full;
                rx_rdy_n = (rx_count < trig_lvl);
            end
            default: begin
                tx_rdy_n = (tx_count != '0);
                rx_rdy_n = (rx_count == '0);
            end
        endcase
        rx_irq   = (rx_count >= trig_lvl);
        mf_out_n = (alt_sel == ALT_RXRDY) ? rx_rdy_n : 1'b1;
    end

    AST_PIN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel != ALT_RXRDY) |-> mf_out_n); // R11
    AST_BLOCK_TX_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_BLOCK) && !tx_full) |-> !tx_rdy_n); // R8
    AST_SINGLE_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MD_BLOCK) && (tx_count == '0)) |-> !tx_rdy_n); // R6

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic [1:0]    alt_sel,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_push_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    output logic          tx_avail,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_pop_data,
    output logic          rx_avail,
    output logic          tx_rdy_n,
    output logic          mf_out_n,
    output logic          rx_irq,
    output logic          rx_overrun
);

    ready_mode_e   mode;
    logic [CW-1:0] trig_lvl, tx_count, rx_count;
    logic          rx_clr, tx_clr, hold;
    logic          tx_full, tx_empty, rx_empty, rx_drop;
    logic          unused_rx_full, unused_tx_drop;

    assign hold = (mode == MD_HOLD);

    uart_fifo_cfg #(.CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode(mode), .trig_lvl(trig_lvl), .rx_clr(rx_clr), .tx_clr(tx_clr)
    );

    uart_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .one_slot(hold),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .pop_data(tx_pop_data), .count(tx_count), .full(tx_full),
        .empty(tx_empty), .drop(unused_tx_drop)
    );

    uart_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .one_slot(hold),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .pop_data(rx_pop_data), .count(rx_count), .full(unused_rx_full),
        .empty(rx_empty), .drop(rx_drop)
    );

    uart_fifo_rdy #(.CW(CW)) u_rdy (
        .clk(clk), .rst_n(rst_n), .mode(mode), .trig_lvl(trig_lvl),
        .tx_count(tx_count), .tx_full(tx_full), .rx_count(rx_count),
        .alt_sel(alt_sel), .tx_rdy_n(tx_rdy_n), .mf_out_n(mf_out_n),
        .rx_irq(rx_irq)
    );

    assign tx_avail = !tx_empty;
    assign rx_avail = !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_overrun <= 1'b0;
        else if (rx_clr)  rx_overrun <= 1'b0;
        else if (rx_drop) rx_overrun <= 1'b1;
    end

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && (rx_count == CW'(DEPTH)) && !rx_clr) |=> rx_overrun); // R12
    AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ((rx_count <= CW'(1)) && (tx_count <= CW'(1)))); // R5

endmodule

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] alt_sel = 2'b01;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_push_data = '0, rx_push_data = '0;
    logic [7:0] tx_pop_data, rx_pop_data;
    logic       tx_avail, rx_avail, tx_rdy_n, mf_out_n, rx_irq, rx_overrun;

    always #2.5 clk = ~clk;

    uart_fifo_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .alt_sel(alt_sel), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_avail(tx_avail),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_avail(rx_avail), .tx_rdy_n(tx_rdy_n),
        .mf_out_n(mf_out_n), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] q_rx[$];
    logic [7:0] q_tx[$];
    bit m_hold = 1, m_blk = 0, m_ovr = 0;
    int m_tcode = 0;

    function automatic int trig_of(int c);
        case (c)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int cap();
        return m_hold ? 1 : DEPTH;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [7:0] d);
        cfg_we = 1; cfg_wdata = d;
        tick();
        cfg_we = 0;
        if ((!d[0]) != m_hold) begin q_rx.delete(); q_tx.delete(); m_ovr = 0; end
        if (d[1]) begin q_rx.delete(); m_ovr = 0; end
        if (d[2]) q_tx.delete();
        m_hold = !d[0]; m_blk = d[3]; m_tcode = int'(d[7:6]);
    endtask

    task automatic rx_in(logic [7:0] d);
        rx_push = 1; rx_push_data = d;
        tick();
        rx_push = 0;
        if (q_rx.size() < cap()) q_rx.push_back(d); else m_ovr = 1;
    endtask

    task automatic tx_in(logic [7:0] d);
        tx_push = 1; tx_push_data = d;
        tick();
        tx_push = 0;
        if (q_tx.size() < cap()) q_tx.push_back(d);
    endtask

    task automatic rx_out(string req);
        if (q_rx.size() > 0) check(req, int'(rx_pop_data), int'(q_rx[0]));
        rx_pop = 1; tick(); rx_pop = 0;
        if (q_rx.size() > 0) void'(q_rx.pop_front());
    endtask

    task automatic tx_out(string req);
        if (q_tx.size() > 0) check(req, int'(tx_pop_data), int'(q_tx[0]));
        tx_pop = 1; tick(); tx_pop = 0;
        if (q_tx.size() > 0) void'(q_tx.pop_front());
    endtask

    task automatic rx_state();
        int cnt = q_rx.size();
        int tl = m_hold ? 1 : trig_of(m_tcode);
        bit rdy_n = (m_hold || !m_blk) ? (cnt == 0) : (cnt < tl);
        check((m_hold || !m_blk) ? "R7 rx ready" : "R9 rx ready",
              int'(mf_out_n), (alt_sel == 2'b01) ? int'(rdy_n) : 1);
        check("R10 rx irq", int'(rx_irq), int'(cnt >= tl));
        check("R1 rx avail", int'(rx_avail), int'(cnt > 0));
        check("R12 overrun", int'(rx_overrun), int'(m_ovr));
    endtask

    task automatic tx_state();
        int cnt = q_tx.size();
        bit blk = !m_hold && m_blk;
        check(blk ? "R8 tx ready" : "R6 tx ready", int'(tx_rdy_n),
              blk ? int'(cnt == DEPTH) : int'(cnt != 0));
        check("R1 tx avail", int'(tx_avail), int'(cnt > 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R2 reset state: queues disabled, single-character policy
        check("R6 reset tx_rdy_n", int'(tx_rdy_n), 0);
        check("R7 reset mf_out_n", int'(mf_out_n), 1);
        check("R10 reset irq", int'(rx_irq), 0);
        check("R12 reset overrun", int'(rx_overrun), 0);
        check("R2 reset avail", int'({tx_avail, rx_avail}), 0);

        // R5 holding mode: one byte per direction
        rx_in(8'hA5); rx_state();
        rx_in(8'h5A); rx_state();
        rx_out("R5 hold rx data"); rx_state();
        tx_in(8'h11); tx_state();
        tx_in(8'h22); tx_state();
        tx_out("R5 hold tx data"); tx_state();

        // R2 block bit ignored while disabled
        cfg_write(8'h08);
        rx_in(8'h33); rx_state();
        tx_in(8'h44); tx_state();
        rx_out("R2 hold rx data"); tx_out("R2 hold tx data");

        // sweep policy x threshold
        for (int md = 0; md < 2; md++) begin
            for (int tc = 0; tc < 4; tc++) begin
                cfg_write({2'(tc), 2'b00, 1'(md), 3'b111});
                rx_state(); tx_state();
                for (int k = 0; k <= DEPTH; k++) begin
                    rx_in(8'((k * 7 + tc * 3 + md) & 8'hFF)); rx_state();
                end
                for (int k = 0; k < DEPTH; k++) begin
                    rx_out("R1 rx order"); rx_state();
                end
                for (int k = 0; k <= DEPTH; k++) begin
                    tx_in(8'((k * 13 + tc) & 8'hFF)); tx_state();
                end
                for (int k = 0; k < DEPTH; k++) begin
                    tx_out("R1 tx order"); tx_state();
                end
            end
        end

        // R2 bits 5:4 ignored: block, threshold 4
        cfg_write(8'h7F);
        for (int k = 0; k < 4; k++) begin rx_in(8'(k + 1)); rx_state(); end

        // R3 self-clearing flush bits
        for (int k = 0; k < 3; k++) tx_in(8'(k + 64));
        cfg_write(8'h4B);
        rx_state(); tx_state();
        check("R3 tx kept", int'(tx_pop_data), 64);
        rx_in(8'h77);
        cfg_write(8'h49);
        check("R3 no repeat clear", int'(rx_avail), 1);
        tx_state();
        cfg_write(8'h4D);
        tx_state(); rx_state();

        // R4 enable change flushes, repeat does not
        rx_in(8'h10); tx_in(8'h20);
        cfg_write(8'h49);
        check("R4 same enable keeps", int'(rx_avail & tx_avail), 1);
        cfg_write(8'h48);
        check("R4 disable flush", int'(rx_avail | tx_avail), 0);
        rx_in(8'h12);
        cfg_write(8'h49);
        check("R4 enable flush", int'(rx_avail), 0);

        // R11 pin select sweep
        cfg_write(8'h07);
        rx_in(8'h99);
        for (int s = 0; s < 4; s++) begin
            alt_sel = 2'(s); tick();
            check("R11 pin busy", int'(mf_out_n), (s == 1) ? 0 : 1);
        end
        rx_out("R11 data");
        for (int s = 0; s < 4; s++) begin
            alt_sel = 2'(s); tick();
            check("R11 pin idle", int'(mf_out_n), 1);
        end
        alt_sel = 2'b01;

        // R13 push and pop together on a full queue
        for (int k = 0; k < DEPTH; k++) begin rx_in(8'(k + 100)); tx_in(8'(k + 150)); end
        check("R13 rx head", int'(rx_pop_data), 100);
        rx_push = 1; rx_push_data = 8'hEE; rx_pop = 1;
        tx_push = 1; tx_push_data = 8'hDD; tx_pop = 1;
        tick();
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        void'(q_rx.pop_front()); q_rx.push_back(8'hEE);
        void'(q_tx.pop_front()); q_tx.push_back(8'hDD);
        check("R13 no overrun", int'(rx_overrun), 0);
        rx_state(); tx_state();
        for (int k = 0; k < DEPTH; k++) begin rx_out("R13 rx order"); tx_out("R13 tx order"); end
        rx_state(); tx_state();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule